// File: doc/BRIEF.md
# Partial-Sum Reduction Node for Row-Split Convolution

This block sits at the meeting point of a group of row workers in a convolution engine. A K×K kernel is split by rows, and each of the N worker lanes (N equals K) computes a 1×K dot product for one row of the current window. When a lane finishes, it raises its done line and holds it, together with its partial sum. The node captures each lane's value when that lane's done is first seen. Once every lane has reported, the node adds the N values and presents the total with its output address for one cycle. It then sends a single acknowledge pulse that all lanes share. On that pulse the lanes slide their window one column to the right.

A row of outputs is opened by a start pulse that carries a base address. For a feature-map width W and stride 1, the row holds W−K+1 windows. The output address is the base plus the index of the window, and a slide counter reports how many windows have been acknowledged. After the last window the node pulses a row-complete flag and goes idle until the next start. The defaults are a 3-row kernel over a 15-pixel-wide row.

Top module: `rsn_reduce_node`

## Requirements
- R1: During reset and on the first cycle after reset, out_valid, lane_ack and row_done are 0 and slide_cnt is 0.
- R2: out_valid stays 0 while any lane has not raised done in the current window.
- R3: out_data is the sum modulo 2^32 of the N captured partial sums. Lane i occupies bits [32*i+31:32*i] of lane_psum.
- R4: out_valid is high for exactly one cycle. That cycle is two clock cycles after the cycle in which the last lane's done is first high.
- R5: lane_ack is high for exactly one cycle, the cycle right after out_valid. All done flags are cleared by it.
- R6: Each lane's partial sum is captured in the cycle its done is first seen. Later changes on lane_psum while done is held do not affect out_data.
- R7: out_addr during out_valid equals row_base (latched at start) plus the window index, modulo 2^ADDR_W. slide_cnt equals the window index during out_valid and rises by one in the cycle after lane_ack.
- R8: After W−K+1 acknowledged windows, row_done is high for one cycle, the cycle after the last lane_ack, and slide_cnt reads W−K+1. The node then ignores lane_done until the next row_start.
- R9: row_start while a row is in progress is ignored. The address base and the window count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start | input | 1 | Opens a row when the node is idle |
| row_base | input | ADDR_W | First output address of the row, sampled with row_start |
| lane_done | input | N_LANES | Per-lane done, held until lane_ack |
| lane_psum | input | N_LANES*32 | Per-lane partial sums, lane i in bits [32*i+31:32*i] |
| lane_ack | output | 1 | Broadcast acknowledge that releases all lanes to slide |
| out_valid | output | 1 | Output write strobe |
| out_addr | output | ADDR_W | Output write address |
| out_data | output | 32 | Sum of the lane partial sums |
| row_done | output | 1 | One-cycle pulse after the last window of the row |
| slide_cnt | output | CNT_W | Windows acknowledged in the current row |

## Verification
If a done flag is lost or set when it should not be, the result shows up in the window it affects. out_valid arrives early, arrives late, or never arrives, and the bench times every strobe to the exact cycle. A value captured at the wrong moment gives a wrong sum in that same window, because the bench changes each lane's partial sum right after done rises. A counter or base register that drifts shows up at once as a wrong out_addr or slide_cnt. An off-by-one at the end of the row shows up as a missing or misplaced row_done on the final window.

// File: rtl/rsn_pkg.sv
// Shared types for the reduction node.
// Assumes: 32-bit partial sums with wrap-around addition.
package rsn_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WRITE   = 2'd2,
        ST_ACK     = 2'd3
    } rsn_state_e;
endpackage

// File: rtl/rsn_lane_latch.sv
// One lane's done flag and captured partial sum.
// Assumes: done is held high by the lane until the acknowledge; capture only while armed.
module rsn_lane_latch
    import rsn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              clear,
    input  logic              done,
    input  logic [DATA_W-1:0] psum,
    output logic              flag,
    output logic [DATA_W-1:0] value
);
    // Set flag and capture on the first done seen while armed; clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            value <= '0;
        end else if (clear) begin
            flag <= 1'b0;
        end else if (arm && done && !flag) begin
            flag  <= 1'b1;
            value <= psum;
        end
    end
endmodule

// File: rtl/rsn_sum_chain.sv
// Combinational wrap-around sum of N captured values.
// Assumes: values packed lane 0 in the low word.
module rsn_sum_chain
    import rsn_pkg::*;
#(
    parameter int N_LANES = 3
) (
    input  logic [N_LANES*DATA_W-1:0] values,
    output logic [DATA_W-1:0]         total
);
    logic [DATA_W-1:0] part [N_LANES+1];

    assign part[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < N_LANES; gi++) begin : g_add
            // Running sum through lane gi.
            assign part[gi+1] = part[gi] + values[gi*DATA_W +: DATA_W];
        end
    endgenerate

    assign total = part[N_LANES];
endmodule

// File: rtl/rsn_addr_gen.sv
// Output address and window counter across one feature-map row.
// Assumes: load and step are never high together.
module rsn_addr_gen #(
    parameter int ADDR_W      = 16,
    parameter int OUT_PER_ROW = 13,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              last
);
    // Latch base on load; count windows on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt    <= '0;
        end else if (load) begin
            base_q <= base;
            cnt    <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign addr = base_q + ADDR_W'(cnt);
    assign last = (cnt == CNT_W'(OUT_PER_ROW - 1));
endmodule

// File: rtl/rsn_reduce_node.sv
// Reduction node: waits for all lanes' done, sums, writes, broadcasts acknowledge.
// Assumes: lanes hold done until lane_ack, and drop it before the cycle after lane_ack.
module rsn_reduce_node
    import rsn_pkg::*;
#(
    parameter int N_LANES = 3,
    parameter int IMG_W   = 15,
    parameter int ADDR_W  = 16,
    localparam int OUT_PER_ROW = IMG_W - N_LANES + 1,
    localparam int CNT_W       = $clog2(OUT_PER_ROW + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      row_start,
    input  logic [ADDR_W-1:0]         row_base,
    input  logic [N_LANES-1:0]        lane_done,
    input  logic [N_LANES*DATA_W-1:0] lane_psum,
    output logic                      lane_ack,
    output logic                      out_valid,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [DATA_W-1:0]         out_data,
    output logic                      row_done,
    output logic [CNT_W-1:0]          slide_cnt
);
    rsn_state_e                state_q;
    logic [N_LANES-1:0]        flag_q;
    logic [N_LANES*DATA_W-1:0] value_q;
    logic [DATA_W-1:0]         sum_w;
    logic [DATA_W-1:0]         total_q;
    logic [ADDR_W-1:0]         base_q;
    logic                      last_w;
    logic                      row_done_q;
    logic                      all_in;
    logic                      load_w;

    assign all_in = &flag_q;
    assign load_w = (state_q == ST_IDLE) && row_start;

    genvar gl;
    generate
        for (gl = 0; gl < N_LANES; gl++) begin : g_lane
            rsn_lane_latch u_latch (
                .clk   (clk),
                .rst_n (rst_n),
                .arm   (state_q == ST_COLLECT),
                .clear (lane_ack),
                .done  (lane_done[gl]),
                .psum  (lane_psum[gl*DATA_W +: DATA_W]),
                .flag  (flag_q[gl]),
                .value (value_q[gl*DATA_W +: DATA_W])
            );
        end
    endgenerate

    rsn_sum_chain #(.N_LANES(N_LANES)) u_sum (
        .values (value_q),
        .total  (sum_w)
    );

    rsn_addr_gen #(
        .ADDR_W      (ADDR_W),
        .OUT_PER_ROW (OUT_PER_ROW),
        .CNT_W       (CNT_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_w),
        .base   (row_base),
        .step   (lane_ack),
        .base_q (base_q),
        .addr   (out_addr),
        .cnt    (slide_cnt),
        .last   (last_w)
    );

    // Sequence control: idle, collect, write, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            total_q    <= '0;
            row_done_q <= 1'b0;
        end else begin
            row_done_q <= 1'b0;
            case (state_q)
                ST_IDLE:    if (row_start) state_q <= ST_COLLECT;
                ST_COLLECT: if (all_in) begin
                                total_q <= sum_w;
                                state_q <= ST_WRITE;
                            end
                ST_WRITE:   state_q <= ST_ACK;
                ST_ACK:     if (last_w) begin
                                state_q    <= ST_IDLE;
                                row_done_q <= 1'b1;
                            end else begin
                                state_q <= ST_COLLECT;
                            end
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (state_q == ST_WRITE);
    assign lane_ack  = (state_q == ST_ACK);
    assign out_data  = total_q;
    assign row_done  = row_done_q;
endmodule

// File: rtl/rsn_reduce_node_chk.sv
// Protocol checker for the reduction node, bound into every instance.
module rsn_reduce_node_chk #(
    parameter int N_LANES     = 3,
    parameter int ADDR_W      = 16,
    parameter int OUT_PER_ROW = 13,
    parameter int CNT_W       = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lane_ack,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               row_done,
    input logic [CNT_W-1:0]   slide_cnt,
    input logic [N_LANES-1:0] flag_q,
    input logic [ADDR_W-1:0]  base_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !lane_ack && !row_done && slide_cnt == '0));

    a_r2_valid_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(&flag_q));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r5_ack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> lane_ack);

    a_r5_ack_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ack |-> $past(out_valid));

    a_r5_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ack |=> (flag_q == '0));

    a_r7_addr_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr == base_q + ADDR_W'(slide_cnt)));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ack |=> (slide_cnt == $past(slide_cnt) + 1'b1));

    a_r8_row_end: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> ($past(lane_ack) && slide_cnt == CNT_W'(OUT_PER_ROW)));
endmodule

bind rsn_reduce_node rsn_reduce_node_chk #(
    .N_LANES     (N_LANES),
    .ADDR_W      (ADDR_W),
    .OUT_PER_ROW (OUT_PER_ROW),
    .CNT_W       (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_ack  (lane_ack),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .row_done  (row_done),
    .slide_cnt (slide_cnt),
    .flag_q    (flag_q),
    .base_q    (base_q)
);

// File: tb/rsn_reduce_node_tb_top.sv
// Sweep bench: every window of several rows with varied lane arrival orders.
module rsn_reduce_node_tb_top;
    localparam int N   = 3;
    localparam int W   = 15;
    localparam int AW  = 16;
    localparam int OPR = W - N + 1;
    localparam int CW  = $clog2(OPR + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              row_start = 1'b0;
    logic [AW-1:0]     row_base = '0;
    logic [N-1:0]      lane_done = '0;
    logic [N*32-1:0]   lane_psum = '0;
    logic              lane_ack;
    logic              out_valid;
    logic [AW-1:0]     out_addr;
    logic [31:0]       out_data;
    logic              row_done;
    logic [CW-1:0]     slide_cnt;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rsn_reduce_node #(.N_LANES(N), .IMG_W(W), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_base(row_base),
        .lane_done(lane_done), .lane_psum(lane_psum), .lane_ack(lane_ack),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .row_done(row_done), .slide_cnt(slide_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_val(int seed, int w, int l);
        return 32'hE000_0000 + 32'(seed) * 32'h0100_0193 + 32'(w * 977) + 32'(l * 31337);
    endfunction

    task automatic run_row(input logic [AW-1:0] base, input int seed, input bit restart);
        @(negedge clk);
        row_start = 1'b1;
        row_base  = base;
        @(negedge clk);
        row_start = 1'b0;
        for (int w = 0; w < OPR; w++) begin
            int d [N];
            int maxd = 0;
            logic [31:0] exp_sum = '0;
            for (int l = 0; l < N; l++) begin
                d[l] = (w * (l + 1) + seed + l) % 4;
                if (d[l] > maxd) maxd = d[l];
                exp_sum = exp_sum + lane_val(seed, w, l);
            end
            for (int c = 0; c <= maxd + 1; c++) begin
                row_start = (restart && w == 2 && c == 0);
                row_base  = base + 16'd100;
                for (int l = 0; l < N; l++) begin
                    if (c == d[l]) begin
                        lane_done[l] = 1'b1;
                        lane_psum[l*32 +: 32] = lane_val(seed, w, l);
                    end else if (c == d[l] + 1) begin
                        lane_psum[l*32 +: 32] = ~lane_val(seed, w, l);
                    end
                end
                @(negedge clk);
                if (c < maxd + 1)
                    chk(!out_valid, "R2", "out_valid before all done", out_valid, 0);
            end
            row_start = 1'b0;
            chk(out_valid, "R4", "out_valid two cycles after last done", out_valid, 1);
            chk(out_data == exp_sum, "R3/R6", "out_data", out_data, exp_sum);
            chk(out_addr == base + AW'(w), "R7/R9", "out_addr", out_addr, base + AW'(w));
            chk(slide_cnt == CW'(w), "R7", "slide_cnt at write", slide_cnt, w);
            chk(!lane_ack, "R5", "ack during write", lane_ack, 0);
            @(negedge clk);
            chk(lane_ack && !out_valid, "R5/R4", "ack after write", {lane_ack, out_valid}, 2);
            lane_done = '0;
            @(negedge clk);
            chk(!lane_ack, "R5", "ack single cycle", lane_ack, 0);
            chk(slide_cnt == CW'(w + 1), "R7", "slide_cnt after ack", slide_cnt, w + 1);
            chk(row_done == (w == OPR - 1), "R8", "row_done", row_done, (w == OPR - 1));
        end
        // Idle: lane done must be ignored.
        for (int l = 0; l < N; l++) begin
            lane_done[l] = 1'b1;
            lane_psum[l*32 +: 32] = 32'h1234_0000 + 32'(l);
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(!out_valid && !lane_ack && !row_done, "R8", "idle ignores done",
                {out_valid, lane_ack, row_done}, 0);
            chk(slide_cnt == CW'(OPR), "R8", "slide_cnt holds at row end", slide_cnt, OPR);
        end
        lane_done = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !lane_ack && !row_done && slide_cnt == '0, "R1", "in reset",
            {out_valid, lane_ack, row_done, slide_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !lane_ack && !row_done && slide_cnt == '0, "R1", "after reset",
            {out_valid, lane_ack, row_done, slide_cnt}, 0);
        run_row(16'h0000, 0, 1'b0);
        run_row(16'h0400, 1, 1'b1);
        run_row(16'hFFF8, 2, 1'b1);
        run_row(16'h0123, 3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule